// File: doc/BRIEF.md
# RTC Interrupt Flag Generator

This block turns elapsed-time updates of a real-time clock into its three interrupt causes: periodic, alarm and update-ended. It also drives a single interrupt request. Each time the timekeeping logic reports an update, it pulses `upd_valid`. With that pulse it supplies the number of microseconds that passed since the last update, and it raises `sec_tick` when the update crossed a second boundary. The block does not keep time. It reads the current hour, minute and second and the three alarm bytes from outside, together with the two control bytes that select the periodic rate and the interrupt enables.

On every update, the block throws away the old cause flags and computes new ones. A periodic accumulator adds the microsecond increment. When periodic interrupts are on and the accumulator reaches the period chosen by the 4-bit rate, the periodic cause sets and the period is taken out of the accumulator. The alarm cause is evaluated only on second ticks. The update cause follows its enable on every update. The resulting flag byte is held until the next update. The request line pulses for one cycle after each update that left any cause set.

Top module: `rtcirq_flags`

## Requirements
- R1: After synchronous reset, `flags_o` is 0x00, `irq_o` is 0, and the periodic accumulator is 0. A reset taken in the middle of a run discards any accumulated time.
- R2: `flags_o` changes only at a clock edge that has `upd_valid` high. On each such edge, all four cause bits (7:4) are recomputed from scratch, so a cause from an earlier update never survives. Bits 3:0 are always zero.
- R3: The update cause, `flags_o` bit 4, sets on every update in which `ctrl_b` bit 4 is 1.
- R4: The alarm cause, `flags_o` bit 5, sets on an update only when all of the following hold: `sec_tick` is 1, `ctrl_b` bit 5 is 1, and seconds, minutes and hours each equal their alarm byte.
- R5: The alarm cause stays clear on an update without `sec_tick`, when any one of the three time bytes differs from its alarm byte, or when `ctrl_b` bit 5 is 0.
- R6: The periodic period in microseconds is the integer quotient 1000000 / (65536 >> r), where r is `ctrl_a` bits 3:0. Each update adds `upd_us` to the accumulator. If `ctrl_b` bit 6 is 1 and the sum is at least the period, including the case where the two are equal, the periodic cause (`flags_o` bit 6) sets and one period is subtracted, at most once per update.
- R7: A rate field of 0 never sets the periodic cause.
- R8: While the periodic cause is disabled on an update (`ctrl_b` bit 6 is 0 or the rate is 0), that update clears the accumulator to zero.
- R9: `flags_o` bit 7 is 1 exactly when at least one of bits 6:4 is 1.
- R10: `irq_o` is high for the one cycle that follows an update leaving bit 7 set, and low in every cycle after an idle edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One-cycle strobe: an elapsed-time update |
| upd_us | input | INC_W | Microseconds elapsed in this update |
| sec_tick | input | 1 | This update crossed a second boundary |
| ctrl_a | input | 8 | Control A: bits 3:0 periodic rate |
| ctrl_b | input | 8 | Control B: bit 4 update, bit 5 alarm, bit 6 periodic enable |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| flags_o | output | 8 | Cause byte: bit 4 update, bit 5 alarm, bit 6 periodic, bit 7 any |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The periodic path is driven with several kinds of increments against short, medium and long periods. Some increments fall just short of the period. One lands exactly on it, which separates a greater-or-equal compare from a strictly-greater one. One is much larger than the period, which shows that only one period is removed per update, and a zero-increment update drains the leftover. The alarm is tried in three ways: with a full match but no second tick, with a tick but only the minute differing, and with a match while its enable is off. Each pattern isolates one term of the compare. Disabling the periodic enable, selecting rate 0, and resetting in mid-run each show, through the next periodic result, whether the accumulator was really cleared.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
  localparam int RATE_W = 4;
  // control B enable positions
  localparam int EN_UPD = 4;
  localparam int EN_ALM = 5;
  localparam int EN_PER = 6;
  // cause byte positions
  localparam int CS_UPD = 4;
  localparam int CS_ALM = 5;
  localparam int CS_PER = 6;
  localparam int CS_ANY = 7;
endpackage

// File: rtl/rtcirq_period_lut.sv
module rtcirq_period_lut #(
  parameter int US_PER_SEC = 1000000,
  parameter int BASE_HZ    = 65536,
  parameter int ACC_W      = 24
) (
  input  logic [rtcirq_pkg::RATE_W-1:0] rate,
  output logic [ACC_W-1:0]              period
);
  localparam int N_RATES = 1 << rtcirq_pkg::RATE_W;

  logic [ACC_W-1:0] tab [N_RATES];

  for (genvar i = 0; i < N_RATES; i++) begin : g_rate
    localparam int HZ  = BASE_HZ >> i;
    localparam int PER = (HZ == 0) ? 0 : US_PER_SEC / HZ;
    assign tab[i] = ACC_W'(PER);
  end

  assign period = tab[rate];
endmodule

// File: rtl/rtcirq_periodic.sv
module rtcirq_periodic #(
  parameter int INC_W = 16,
  parameter int ACC_W = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_valid,
  input  logic                          enable,
  input  logic [rtcirq_pkg::RATE_W-1:0] rate,
  input  logic [INC_W-1:0]              inc,
  input  logic [ACC_W-1:0]              period,
  output logic                          hit
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum_wide;
  logic [ACC_W-1:0] sum;
  logic             active;

  assign active   = enable && (rate != '0);
  assign sum_wide = {1'b0, acc} + (ACC_W+1)'(inc);
  assign sum      = sum_wide[ACC_W] ? ACC_MAX : sum_wide[ACC_W-1:0];
  assign hit      = active && (sum >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (upd_valid) begin
      if (!active)  acc <= '0;
      else if (hit) acc <= sum - period;
      else          acc <= sum;
    end
  end
endmodule

// File: rtl/rtcirq_alarm_cmp.sv
module rtcirq_alarm_cmp #(
  parameter int FIELDS = 3
) (
  input  logic [FIELDS-1:0][7:0] now_b,
  input  logic [FIELDS-1:0][7:0] alm_b,
  output logic                   match
);
  logic [FIELDS-1:0] eq;

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    assign eq[f] = (now_b[f] == alm_b[f]);
  end

  assign match = &eq;
endmodule

// File: rtl/rtcirq_flags.sv
module rtcirq_flags #(
  parameter int US_PER_SEC = 1000000,
  parameter int BASE_HZ    = 65536,
  parameter int INC_W      = 16,
  parameter int ACC_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [INC_W-1:0] upd_us,
  input  logic             sec_tick,
  input  logic [7:0]       ctrl_a,
  input  logic [7:0]       ctrl_b,
  input  logic [7:0]       cur_sec,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hour,
  input  logic [7:0]       alm_sec,
  input  logic [7:0]       alm_min,
  input  logic [7:0]       alm_hour,
  output logic [7:0]       flags_o,
  output logic             irq_o
);
  import rtcirq_pkg::*;

  logic [RATE_W-1:0] rate;
  logic [ACC_W-1:0]  period;
  logic              per_hit;
  logic              alm_match;
  logic              uf_n, af_n, pf_n, any_n;

  assign rate = ctrl_a[RATE_W-1:0];

  rtcirq_period_lut #(
    .US_PER_SEC(US_PER_SEC), .BASE_HZ(BASE_HZ), .ACC_W(ACC_W)
  ) u_lut (
    .rate(rate), .period(period)
  );

  rtcirq_periodic #(
    .INC_W(INC_W), .ACC_W(ACC_W)
  ) u_per (
    .clk(clk), .rst(rst), .upd_valid(upd_valid),
    .enable(ctrl_b[EN_PER]), .rate(rate), .inc(upd_us),
    .period(period), .hit(per_hit)
  );

  rtcirq_alarm_cmp #(.FIELDS(3)) u_alm (
    .now_b({cur_hour, cur_min, cur_sec}),
    .alm_b({alm_hour, alm_min, alm_sec}),
    .match(alm_match)
  );

  assign uf_n  = ctrl_b[EN_UPD];
  assign af_n  = ctrl_b[EN_ALM] && sec_tick && alm_match;
  assign pf_n  = per_hit;
  assign any_n = uf_n || af_n || pf_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else if (upd_valid) begin
      flags_o         <= '0;
      flags_o[CS_UPD] <= uf_n;
      flags_o[CS_ALM] <= af_n;
      flags_o[CS_PER] <= pf_n;
      flags_o[CS_ANY] <= any_n;
      irq_o           <= any_n;
    end else begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcirq_flags_chk.sv
module rtcirq_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd_valid,
  input logic       sec_tick,
  input logic [7:0] ctrl_a,
  input logic [7:0] ctrl_b,
  input logic [7:0] flags_o,
  input logic       irq_o
);
  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(flags_o));

  // R3
  upd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && ctrl_b[4]) |=> flags_o[4]);

  // R5
  alarm_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !sec_tick) |=> !flags_o[5]);

  // R7
  rate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && ctrl_a[3:0] == 4'd0) |=> !flags_o[6]);

  // R9
  any_bit_chk: assert property (@(posedge clk) disable iff (rst)
    flags_o[7] == (flags_o[6:4] != 3'b000));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (irq_o == flags_o[7]));

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !irq_o);
endmodule

bind rtcirq_flags rtcirq_flags_chk u_chk (
  .clk(clk), .rst(rst), .upd_valid(upd_valid), .sec_tick(sec_tick),
  .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/rtcirq_flags_test.sv
module rtcirq_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int INC_W = 16;
  localparam int NV = 15;

  // {ctrl_a, ctrl_b, inc, sec_tick, alarm_match, expected flags}
  localparam logic [41:0] VEC [NV] = '{
    {8'h26, 8'h40, 16'd500,   1'b0, 1'b0, 8'h00}, // R6 below period 976
    {8'h26, 8'h40, 16'd500,   1'b0, 1'b0, 8'hC0}, // R6 1000 >= 976, left 24
    {8'h26, 8'h50, 16'd100,   1'b0, 1'b0, 8'h90}, // R3 acc 124
    {8'h26, 8'h70, 16'd100,   1'b1, 1'b1, 8'hB0}, // R4 alarm match on tick
    {8'h26, 8'h70, 16'd100,   1'b0, 1'b1, 8'h90}, // R5 no tick, R2 alarm gone
    {8'h26, 8'h20, 16'd100,   1'b1, 1'b0, 8'h00}, // R5 minute differs, R8 clear
    {8'h26, 8'h20, 16'd0,     1'b1, 1'b1, 8'hA0}, // R4 alarm alone
    {8'h20, 8'h40, 16'd60000, 1'b0, 1'b0, 8'h00}, // R7 rate 0
    {8'h2F, 8'h40, 16'd60000, 1'b0, 1'b0, 8'h00}, // R8 acc was cleared, 60000<500000
    {8'h23, 8'h40, 16'd100,   1'b0, 1'b0, 8'hC0}, // R6 60100>=122, one subtraction
    {8'h23, 8'h40, 16'd0,     1'b0, 1'b0, 8'hC0}, // R6 leftover 59978 still >=122
    {8'h21, 8'h00, 16'd5,     1'b0, 1'b0, 8'h00}, // R8 disabled clears
    {8'h21, 8'h40, 16'd29,    1'b0, 1'b0, 8'h00}, // R6 29 < 30
    {8'h21, 8'h40, 16'd1,     1'b0, 1'b0, 8'hC0}, // R6 equal to period
    {8'h21, 8'h10, 16'd0,     1'b1, 1'b1, 8'h90}  // R5 alarm enable off
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             upd_valid = 1'b0;
  logic [INC_W-1:0] upd_us = '0;
  logic             sec_tick = 1'b0;
  logic [7:0]       ctrl_a = 8'h26;
  logic [7:0]       ctrl_b = 8'h00;
  logic [7:0]       cur_sec = 8'h56, cur_min = 8'h34, cur_hour = 8'h12;
  logic [7:0]       alm_sec = 8'h56, alm_min = 8'h34, alm_hour = 8'h12;
  logic [7:0]       flags_o;
  logic             irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcirq_flags #(.INC_W(INC_W)) uut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_us(upd_us),
    .sec_tick(sec_tick), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_update(input logic [7:0] a, input logic [7:0] b,
                           input logic [15:0] inc, input logic tick, input logic match);
    @(negedge clk);
    ctrl_a    = a;
    ctrl_b    = b;
    upd_us    = inc;
    sec_tick  = tick;
    alm_min   = match ? cur_min : cur_min + 8'h01;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    sec_tick  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags after reset", flags_o, 8'h00);
    check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_update(VEC[i][41:34], VEC[i][33:26], VEC[i][25:10], VEC[i][9], VEC[i][8]);
      check($sformatf("R2/R9 vector %0d flags", i), flags_o, VEC[i][7:0]);
      check($sformatf("R10 vector %0d irq", i), {7'd0, irq_o}, {7'd0, VEC[i][7]});
    end

    // R10 and R2: idle edge drops irq, flags held
    do_update(8'h26, 8'h10, 16'd0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 irq after idle edge", {7'd0, irq_o}, 8'h00);
    check("R2 flags held while idle", flags_o, 8'h90);
    // stimulus changes without update do not move flags
    ctrl_b = 8'h70; sec_tick = 1'b1; alm_min = cur_min;
    @(negedge clk);
    check("R2 flags ignore inputs without update", flags_o, 8'h90);
    sec_tick = 1'b0;

    // R1 mid-run reset clears accumulator
    do_update(8'h26, 8'h40, 16'd900, 1'b0, 1'b0);
    check("R6 900 below 976", flags_o, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 flags on mid-run reset", flags_o, 8'h00);
    rst = 1'b0;
    do_update(8'h26, 8'h40, 16'd100, 1'b0, 1'b0);
    check("R1 accumulator discarded by reset", flags_o, 8'h00);
    do_update(8'h26, 8'h40, 16'd876, 1'b0, 1'b0);
    check("R6 reaches period after reset", flags_o, 8'hC0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule